// File: doc/BRIEF.md
# Three-Read, Two-Write Register File with Deferred Second Write

This block is a register file with three read ports that accepts up to two writes per cycle, while its storage has only one real write port. The storage is held as one copy per read port; all copies share the single write port, so each read port has a private read path and all copies stay identical.

When both write ports carry requests in the same cycle, port A is committed at once and port B is parked in a one-entry deferred-write buffer. The buffer drains into the storage on the next cycle. If a write is presented while the buffer is full, the block raises `stall` for that cycle and ignores the request, so the caller must present it again. Reads return the newest value. A write accepted in the current cycle is forwarded to the read ports. The buffered entry is forwarded when a read hits its address. The storage output is used otherwise.

Top module: `rf2w_regfile`

## Requirements
- R1: After synchronous active-high reset the deferred-write buffer is empty, so `stall` is 0 in the first cycle after reset even when both write ports request.
- R2: A single accepted write on either port is returned by every read port addressing that register in the same cycle and in all later cycles until overwritten.
- R3: Two accepted writes to distinct registers in the same cycle are both returned by reads in that cycle and in all later cycles.
- R4: For one cycle after a dual write, port B's value sits in the buffer, and reads of its address return the buffered value. The buffer is empty in the following cycle.
- R5: `stall` is 1 exactly when the buffer is full and at least one write enable is high. It never stays high for two cycles in a row.
- R6: A write presented while `stall` is 1 has no effect on any register, and it is not forwarded to the reads.
- R7: When both ports write the same register in one cycle, port B's data is stored, only one write is performed, and the buffer stays empty.
- R8: A read of a register written in the current accepted cycle returns the new data, and port B takes priority over port A.
- R9: The three read ports are independent: each returns the value of its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wa_en | input | 1 | Write port A enable |
| wa_addr | input | AW | Write port A register index |
| wa_data | input | DW | Write port A data |
| wb_en | input | 1 | Write port B enable |
| wb_addr | input | AW | Write port B register index |
| wb_data | input | DW | Write port B data |
| rd0_addr | input | AW | Read port 0 index |
| rd0_data | output | DW | Read port 0 data |
| rd1_addr | input | AW | Read port 1 index |
| rd1_data | output | DW | Read port 1 data |
| rd2_addr | input | AW | Read port 2 index |
| rd2_data | output | DW | Read port 2 data |
| stall | output | 1 | Buffer busy: the presented write is ignored this cycle |

## Verification
The bench builds the block with 8 registers of 16 bits. With so few registers, random writes often land on the same address, on the buffered address, or on an address that a read port is reading in the same cycle. This exercises the same-address rule, the forwarding priorities and the stall-and-retry sequence often, alongside the directed cases. The small data width also keeps values readable in failure lines.

// File: rtl/rf2w_pkg.sv
package rf2w_pkg;
  typedef enum logic [1:0] {
    CMT_NONE   = 2'd0,
    CMT_PORT_A = 2'd1,
    CMT_PORT_B = 2'd2,
    CMT_BUFFER = 2'd3
  } commit_src_e;

  localparam int unsigned NUM_RD = 3;
endpackage

// File: rtl/rf2w_write_ctrl.sv
module rf2w_write_ctrl
  import rf2w_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_data,
  output logic          stall,
  output logic          acc_a,
  output logic          acc_b,
  output commit_src_e   cmt_src,
  output logic          cmt_en,
  output logic [AW-1:0] cmt_addr,
  output logic [DW-1:0] cmt_data,
  output logic          buf_valid,
  output logic [AW-1:0] buf_addr,
  output logic [DW-1:0] buf_data
);
  logic accept;
  logic same_target;
  logic defer_b;

  assign accept      = !buf_valid;
  assign same_target = a_en && b_en && (a_addr == b_addr);
  assign acc_a       = accept && a_en && !same_target;
  assign acc_b       = accept && b_en;
  assign defer_b     = acc_a && acc_b;
  assign stall       = buf_valid && (a_en || b_en);

  always_comb begin
    if (buf_valid)  cmt_src = CMT_BUFFER;
    else if (acc_a) cmt_src = CMT_PORT_A;
    else if (acc_b) cmt_src = CMT_PORT_B;
    else            cmt_src = CMT_NONE;
  end

  always_comb begin
    cmt_en   = (cmt_src != CMT_NONE);
    cmt_addr = a_addr;
    cmt_data = a_data;
    case (cmt_src)
      CMT_BUFFER: begin cmt_addr = buf_addr; cmt_data = buf_data; end
      CMT_PORT_B: begin cmt_addr = b_addr;   cmt_data = b_data;   end
      default:    begin cmt_addr = a_addr;   cmt_data = a_data;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_valid <= 1'b0;
    end else begin
      buf_valid <= defer_b;
    end
  end

  always_ff @(posedge clk) begin
    if (defer_b) begin
      buf_addr <= b_addr;
      buf_data <= b_data;
    end
  end

  p_stall_single_r5: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);
  p_buffer_drains_r4: assert property (@(posedge clk) disable iff (rst)
    buf_valid |=> !buf_valid);
  p_defer_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (!buf_valid && a_en && b_en && (a_addr != b_addr)) |=>
      (buf_valid && buf_addr == $past(b_addr) && buf_data == $past(b_data)));
  p_stall_drains_r6: assert property (@(posedge clk) disable iff (rst)
    stall |-> (cmt_src == CMT_BUFFER && !acc_a && !acc_b));
  p_same_target_r7: assert property (@(posedge clk) disable iff (rst)
    (!buf_valid && a_en && b_en && (a_addr == b_addr)) |=> !buf_valid);
endmodule

// File: rtl/rf2w_store_copy.sv
module rf2w_store_copy #(
  parameter int unsigned AW    = 5,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/rf2w_read_path.sv
module rf2w_read_path #(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input  logic [AW-1:0] raddr,
  input  logic [DW-1:0] store_q,
  input  logic          acc_a,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  input  logic          acc_b,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_data,
  input  logic          buf_valid,
  input  logic [AW-1:0] buf_addr,
  input  logic [DW-1:0] buf_data,
  output logic          hit_buf,
  output logic          hit_new,
  output logic [DW-1:0] rdata
);
  // Newest first: port B this cycle, port A this cycle, buffer, storage.
  function automatic logic [DW-1:0] newest(
    input logic [AW-1:0] ra,
    input logic hb, input logic [AW-1:0] ab, input logic [DW-1:0] db,
    input logic ha, input logic [AW-1:0] aa, input logic [DW-1:0] da,
    input logic hq, input logic [AW-1:0] aq, input logic [DW-1:0] dq,
    input logic [DW-1:0] ds);
    if (hb && ab == ra)      return db;
    else if (ha && aa == ra) return da;
    else if (hq && aq == ra) return dq;
    else                     return ds;
  endfunction

  assign hit_new = (acc_b && b_addr == raddr) || (acc_a && a_addr == raddr);
  assign hit_buf = buf_valid && buf_addr == raddr;
  assign rdata   = newest(raddr, acc_b, b_addr, b_data, acc_a, a_addr, a_data,
                          buf_valid, buf_addr, buf_data, store_q);
endmodule

// File: rtl/rf2w_regfile.sv
module rf2w_regfile
  import rf2w_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  input  logic [AW-1:0] rd0_addr,
  output logic [DW-1:0] rd0_data,
  input  logic [AW-1:0] rd1_addr,
  output logic [DW-1:0] rd1_data,
  input  logic [AW-1:0] rd2_addr,
  output logic [DW-1:0] rd2_data,
  output logic          stall
);
  logic          acc_a, acc_b, cmt_en, buf_valid;
  commit_src_e   cmt_src;
  logic [AW-1:0] cmt_addr, buf_addr;
  logic [DW-1:0] cmt_data, buf_data;

  logic [AW-1:0] rd_addr  [NUM_RD];
  logic [DW-1:0] rd_data  [NUM_RD];
  logic [DW-1:0] store_q  [NUM_RD];
  logic          hit_buf  [NUM_RD];
  logic          hit_new  [NUM_RD];

  assign rd_addr[0] = rd0_addr;
  assign rd_addr[1] = rd1_addr;
  assign rd_addr[2] = rd2_addr;
  assign rd0_data   = rd_data[0];
  assign rd1_data   = rd_data[1];
  assign rd2_data   = rd_data[2];

  rf2w_write_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst),
    .a_en(wa_en), .a_addr(wa_addr), .a_data(wa_data),
    .b_en(wb_en), .b_addr(wb_addr), .b_data(wb_data),
    .stall(stall), .acc_a(acc_a), .acc_b(acc_b), .cmt_src(cmt_src),
    .cmt_en(cmt_en), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_data(buf_data)
  );

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    rf2w_store_copy #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_copy (
      .clk(clk), .we(cmt_en), .waddr(cmt_addr), .wdata(cmt_data),
      .raddr(rd_addr[g]), .rdata(store_q[g])
    );
    rf2w_read_path #(.AW(AW), .DW(DW)) u_path (
      .raddr(rd_addr[g]), .store_q(store_q[g]),
      .acc_a(acc_a), .a_addr(wa_addr), .a_data(wa_data),
      .acc_b(acc_b), .b_addr(wb_addr), .b_data(wb_data),
      .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_data(buf_data),
      .hit_buf(hit_buf[g]), .hit_new(hit_new[g]), .rdata(rd_data[g])
    );

    p_buffer_bypass_r4: assert property (@(posedge clk) disable iff (rst)
      (hit_buf[g] && !hit_new[g]) |-> (rd_data[g] == buf_data));
    p_write_forward_r8: assert property (@(posedge clk) disable iff (rst)
      (acc_b && wb_addr == rd_addr[g]) |-> (rd_data[g] == wb_data));
  end

  p_reset_empty_r1: assert property (@(posedge clk)
    $past(rst) |-> !stall);
  p_port_a_commits_r2: assert property (@(posedge clk) disable iff (rst)
    (!stall && wa_en && !wb_en) |-> (cmt_en && cmt_addr == wa_addr && cmt_data == wa_data));
endmodule

// File: tb/sim_rf2w_regfile.sv
module sim_rf2w_regfile;
  localparam int P     = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wa_en = 1'b0, wb_en = 1'b0;
  logic [AW-1:0] wa_addr = '0, wb_addr = '0;
  logic [DW-1:0] wa_data = '0, wb_data = '0;
  logic [AW-1:0] rd0_addr = '0, rd1_addr = '0, rd2_addr = '0;
  logic [DW-1:0] rd0_data, rd1_data, rd2_data;
  logic          stall;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [DW-1:0] arch [DEPTH];
  bit pend = 0;

  always #(P/2) clk = ~clk;

  rf2w_regfile #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .rd2_addr(rd2_addr), .rd2_data(rd2_data),
    .stall(stall)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] ra);
    logic [DW-1:0] v;
    v = arch[ra];
    if (!pend && wa_en && wa_addr == ra) v = wa_data;
    if (!pend && wb_en && wb_addr == ra) v = wb_data;
    return v;
  endfunction

  // Drives one cycle from a negedge, checks before the posedge, updates model.
  task automatic step(input bit ae, input int aa, input int ad,
                      input bit be, input int ba, input int bd,
                      input int q0, input int q1, input int q2,
                      input string tag, input bit chk_rd);
    logic exp_stall;
    wa_en = ae; wa_addr = AW'(aa); wa_data = DW'(ad);
    wb_en = be; wb_addr = AW'(ba); wb_data = DW'(bd);
    rd0_addr = AW'(q0); rd1_addr = AW'(q1); rd2_addr = AW'(q2);
    #(P/4);
    exp_stall = pend && (ae || be);
    check(stall === exp_stall, exp_stall ? "R5 stall raised" : "R5 stall low",
          DW'(stall), DW'(exp_stall));
    if (chk_rd) begin
      check(rd0_data === model_read(rd0_addr), tag, rd0_data, model_read(rd0_addr));
      check(rd1_data === model_read(rd1_addr), tag, rd1_data, model_read(rd1_addr));
      check(rd2_data === model_read(rd2_addr), tag, rd2_data, model_read(rd2_addr));
    end
    @(posedge clk);
    if (!pend) begin
      if (ae) arch[AW'(aa)] = DW'(ad);
      if (be) arch[AW'(ba)] = DW'(bd);
      pend = ae && be && (AW'(aa) != AW'(ba));
    end else begin
      pend = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(P * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: buffer empty after reset, dual request must not stall
    step(1, 0, 16'h1000, 1, 1, 16'h1001, 0, 1, 2, "R1", 0);
    // idle cycle drains port B from the buffer
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1", 0);
    // R2: fill every register through port A
    for (int i = 0; i < DEPTH; i++)
      step(1, i, 16'hA000 + i, 0, 0, 0, i, i, i, "R2 single write", i > 0);
    step(0, 0, 0, 0, 0, 0, 0, 3, 7, "R2 readback", 1);
    // R3/R4: dual write, then idle with reads of the buffered address
    step(1, 2, 16'h2222, 1, 5, 16'h5555, 2, 5, 3, "R3 dual write", 1);
    step(0, 0, 0, 0, 0, 0, 5, 2, 5, "R4 buffer bypass", 1);
    step(0, 0, 0, 0, 0, 0, 5, 2, 4, "R4 drained", 1);
    // R5/R6: dual write, then a write during the full buffer is dropped
    step(1, 1, 16'h1111, 1, 6, 16'h6666, 1, 6, 0, "R3 dual write", 1);
    step(1, 4, 16'hDEAD, 0, 0, 0, 4, 6, 1, "R6 stalled write hidden", 1);
    step(0, 0, 0, 0, 0, 0, 4, 6, 1, "R6 stalled write dropped", 1);
    step(1, 4, 16'hBEEF, 0, 0, 0, 4, 4, 4, "R6 retried write", 1);
    // R5: both enables during the full buffer
    step(1, 0, 16'h0A0A, 1, 7, 16'h7777, 0, 7, 3, "R3 dual write", 1);
    step(1, 3, 16'h3333, 1, 3, 16'h3434, 3, 7, 0, "R6 stalled pair", 1);
    // R7: same-address dual write, B wins, no stall afterwards
    step(1, 3, 16'hAAAA, 1, 3, 16'hBBBB, 3, 3, 3, "R7 same address", 1);
    step(1, 2, 16'h0202, 0, 0, 0, 3, 2, 3, "R7 no buffer left", 1);
    // R8: same-cycle forwarding with B over A
    step(1, 6, 16'h6060, 1, 1, 16'h0101, 6, 1, 5, "R8 forward", 1);
    step(0, 0, 0, 0, 0, 0, 6, 1, 5, "R8 after", 1);
    // R9: random traffic, three independent reads
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 4);
      step(r[0], int'($urandom % DEPTH), int'($urandom),
           r[1], int'($urandom % DEPTH), int'($urandom),
           int'($urandom % DEPTH), int'($urandom % DEPTH), int'($urandom % DEPTH),
           "R9 random", 1);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule